// File: doc/BRIEF.md
# Guarded Byte Store

A small byte-wide data memory behind four CPU-visible registers: an address register, a data register, a control register and a write-only key register. Software reads a byte by loading the address and setting the read bit in the control register; the byte lands in the data register at the same clock edge that accepts the control write. This makes it visible on the very next bus read.

Writing is deliberately awkward. Software must set the write-enable bit. It must then store 0x55 and then 0xAA into the key register, with no other bus write between them. Only after that may it set the write bit. The write then occupies the store for `WRITE_CYCLES` clocks with the address and data registers frozen. At the end, hardware clears the write bit and raises a sticky done flag, which can drive an interrupt request. Every byte written needs its own key sequence.

The register bus is plain control traffic: one write strobe, a combinational read mux, and no valid/ready handshake, because every access completes in one cycle and the block never back-pressures.

Top module: `guarded_byte_store`

## Requirements
- R1: After reset, the address, data and control registers read 0x00, every storage byte is 0x00, and `irq` is 0.
- R2: A control write (offset 2) with bit 0 = 1 and bit 7 = 0, outside a write, loads the byte at the current address into the data register at that edge. Control bit 0 reads 1 for one cycle and then 0.
- R3: The data register (offset 1) keeps its value until another read loads it or software writes it directly. Changing the address alone leaves it unchanged.
- R4: A write starts (control bit 1 reads 1) only when the two bus writes just before the control write were 0x55 and then 0xAA to the key register (offset 3). Any other order, a wrong value, or any other bus write between them leaves bit 1 at 0.
- R5: Each start consumes the key sequence. A second control write with bit 1 set and no fresh sequence starts nothing.
- R6: A start also needs the write-enable bit (control bit 2) to be 1 before the control write that sets bit 1. Hardware never clears bit 2.
- R7: Clearing bit 2 during a write neither aborts nor alters it; the byte is still stored.
- R8: Control bit 1 stays 1 for exactly `WRITE_CYCLES` cycles after the starting edge. At the end, it clears, the byte is stored, and the done flag (control bit 3) sets.
- R9: The done flag is sticky. Only a control write with bit 3 = 0 clears it, and writing 1 to bit 3 does not set it.
- R10: `irq` is 1 exactly when the done flag and the interrupt-enable bit (control bit 4) are both 1.
- R11: While a write runs, writes to the address and data registers and read requests are ignored.
- R12: A control write with bit 7 (memory select) = 1 neither reads nor writes the store, whatever bits 0 and 1 hold.
- R13: The key register always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 address, 1 data, 2 control, 3 key |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_rdata | output | 8 | Combinational register read data |
| irq | output | 1 | Write-complete interrupt request |

## Verification
The bench targets key-sequence abuse: reversed bytes, a stray data-register write between 0x55 and 0xAA, and reuse of a consumed sequence. A tracker that ignores interleaved writes or stays armed would show the write bit set where it must stay clear. It times the write bit cycle by cycle, so a timer off by one shows up as a write bit seen set or clear one cycle early or late. It also drops write-enable and changes the address and data mid-write, so a design that aborts or re-latches would store the wrong byte or show changed registers. With memory select set, it checks that neither the data register nor the stored byte changes.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_state_t;

  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_KEY  = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WEN  = 2;
  localparam int CB_DONE = 3;
  localparam int CB_IE   = 4;
  localparam int CB_SEL  = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/gbs_unlock.sv
module gbs_unlock
  import gbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       to_key,
  input  logic [7:0] bus_wdata,
  output logic       armed
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (bus_we) begin
      state_d = KEY_IDLE;
      if (to_key) begin
        unique case (state_q)
          KEY_IDLE: if (bus_wdata == KEY_FIRST)  state_d = KEY_HALF;
          KEY_HALF: if (bus_wdata == KEY_SECOND) state_d = KEY_ARMED;
          default:  state_d = KEY_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KEY_ARMED);

  assert_armed_after_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(state_q == KEY_HALF));
endmodule

// File: rtl/gbs_timer.sv
module gbs_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign finish = busy && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(CYCLES);
    end else if (finish) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));
endmodule

// File: rtl/gbs_store.sv
module gbs_store #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/guarded_byte_store.sv
module guarded_byte_store
  import gbs_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              rd_q, wen_q, done_q, ie_q, sel_q;
  logic              armed, busy, finish;
  logic [7:0]        cell_out;
  logic              unused_bits;

  wire ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
  wire start   = ctrl_wr && reg_wdata[CB_WR] && !reg_wdata[CB_SEL]
                 && wen_q && armed && !busy;
  wire rd_go   = ctrl_wr && reg_wdata[CB_RD] && !reg_wdata[CB_SEL] && !busy;

  assign unused_bits = ^reg_wdata[6:5];

  gbs_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .bus_we(reg_we),
    .to_key(reg_addr == OFS_KEY), .bus_wdata(reg_wdata), .armed(armed)
  );

  gbs_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .finish(finish)
  );

  gbs_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(finish), .addr(addr_q),
    .wdata(data_q), .rdata(cell_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= 8'h00;
      rd_q   <= 1'b0;
      wen_q  <= 1'b0;
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      rd_q <= rd_go;
      if (reg_we && reg_addr == OFS_ADDR && !busy)
        addr_q <= reg_wdata[ADDR_W-1:0];
      if (rd_go)
        data_q <= cell_out;
      else if (reg_we && reg_addr == OFS_DATA && !busy)
        data_q <= reg_wdata;
      if (ctrl_wr) begin
        wen_q <= reg_wdata[CB_WEN];
        ie_q  <= reg_wdata[CB_IE];
        sel_q <= reg_wdata[CB_SEL];
      end
      if (finish)
        done_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[CB_DONE])
        done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_ADDR: reg_rdata = 8'(addr_q);
      OFS_DATA: reg_rdata = data_q;
      OFS_CTRL: reg_rdata = {sel_q, 2'b00, ie_q, done_q, wen_q, busy, rd_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = done_q && ie_q;

  assert_start_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  assert_start_needs_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));
  assert_rd_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q);
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(reg_we && reg_addr == OFS_CTRL && !reg_wdata[CB_DONE]));
  assert_frozen_during_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));
  assert_irq_low_without_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> !irq);
endmodule

// File: tb/guarded_byte_store_test.sv
module guarded_byte_store_test;
  localparam int WC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    bit         is_irq;
    logic [7:0] mask;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #2 clk = ~clk;

  guarded_byte_store #(.ADDR_W(6), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      item_t it;
      logic [7:0] got;
      it  = sbq.pop_front();
      got = it.is_irq ? {7'b0, irq} : (reg_rdata & it.mask);
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk); #1;
    reg_we    = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] m,
                            input logic [7:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.mask = m; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.mask = 8'hFF; it.exp = {7'b0, e}; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic key();
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    expect_reg(2'd0, 8'hFF, 8'h00, "R1 address reset");
    expect_reg(2'd1, 8'hFF, 8'h00, "R1 data reset");
    expect_reg(2'd2, 8'hFF, 8'h00, "R1 control reset");
    expect_irq(1'b0, "R1 irq reset");
    wr(2'd2, 8'h01);
    expect_reg(2'd1, 8'hFF, 8'h00, "R1 storage reset");

    wr(2'd3, 8'h33);
    expect_reg(2'd3, 8'hFF, 8'h00, "R13 key reads zero");

    // first write: byte A7 to address 5, disturbed mid-write
    wr(2'd0, 8'h05);
    wr(2'd1, 8'hA7);
    wr(2'd2, 8'h04);
    key();
    wr(2'd2, 8'h06);
    expect_reg(2'd2, 8'h02, 8'h02, "R4 write started after key");
    wr(2'd2, 8'h00);
    expect_reg(2'd2, 8'h06, 8'h02, "R7 wen cleared, write continues");
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h11);
    wr(2'd2, 8'h01);
    expect_reg(2'd0, 8'hFF, 8'h05, "R11 address frozen");
    expect_reg(2'd1, 8'hFF, 8'hA7, "R11 data frozen");
    expect_reg(2'd2, 8'h01, 8'h00, "R11 read ignored during write");
    repeat (WC) @(posedge clk);
    #1;
    expect_reg(2'd2, 8'h0A, 8'h08, "R8 write done");

    // read back address 5
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h09);
    expect_reg(2'd2, 8'h01, 8'h01, "R2 read bit set");
    expect_reg(2'd2, 8'h01, 8'h00, "R2 read bit self clears");
    expect_reg(2'd1, 8'hFF, 8'hA7, "R7 R2 stored byte read");
    wr(2'd0, 8'h07);
    expect_reg(2'd1, 8'hFF, 8'hA7, "R3 data kept on address change");
    wr(2'd1, 8'h12);
    expect_reg(2'd1, 8'hFF, 8'h12, "R3 direct data write");

    // R6: key without wen
    wr(2'd1, 8'h3C);
    key();
    wr(2'd2, 8'h02);
    expect_reg(2'd2, 8'h02, 8'h00, "R6 blocked without wen");

    // R8 timed write of 3C to address 7
    wr(2'd2, 8'h04);
    key();
    wr(2'd2, 8'h06);
    for (int k = 0; k < WC; k++)
      expect_reg(2'd2, 8'h0A, 8'h02, "R8 write bit held");
    expect_reg(2'd2, 8'h0E, 8'h0C, "R8 R6 end of write, wen kept");
    expect_irq(1'b0, "R10 irq masked");
    wr(2'd2, 8'h1C);
    expect_irq(1'b1, "R10 irq with enable");
    expect_reg(2'd2, 8'h08, 8'h08, "R9 writing 1 keeps done");
    wr(2'd2, 8'h14);
    expect_reg(2'd2, 8'h08, 8'h00, "R9 writing 0 clears done");
    expect_irq(1'b0, "R10 irq drops with done");

    // R5: no reuse of a consumed key
    wr(2'd2, 8'h06);
    expect_reg(2'd2, 8'h02, 8'h00, "R5 key consumed");

    // R4: bad orders
    wr(2'd3, 8'hAA);
    wr(2'd3, 8'h55);
    wr(2'd2, 8'h06);
    expect_reg(2'd2, 8'h02, 8'h00, "R4 reversed key");
    wr(2'd3, 8'h55);
    wr(2'd1, 8'h77);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    expect_reg(2'd2, 8'h02, 8'h00, "R4 interleaved write");
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAB);
    wr(2'd2, 8'h06);
    expect_reg(2'd2, 8'h02, 8'h00, "R4 wrong second byte");

    // R12: memory select blocks both accesses
    wr(2'd1, 8'h99);
    key();
    wr(2'd2, 8'h86);
    expect_reg(2'd2, 8'h02, 8'h00, "R12 write blocked by select");
    repeat (WC + 2) @(posedge clk);
    #1;
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'h85);
    expect_reg(2'd1, 8'hFF, 8'h5A, "R12 read blocked by select");
    wr(2'd2, 8'h05);
    expect_reg(2'd1, 8'hFF, 8'h3C, "R12 R8 stored byte intact");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule